// File: doc/BRIEF.md
# ADC Conversion Clock and Sample Window Generator

This block sits between the fast module clock of an analog-to-digital converter and its converter core. It turns the module clock into a basic conversion clock and opens a sampling window whose length is a whole number of basic-clock periods. The basic clock is not a derived clock. It is a one-cycle enable pulse on the module clock, so every downstream register stays in a single clock domain.

Timing settings come from one of four configuration sources. The first is a legacy pair of 2-bit codes, whose clock code is deliberately non-monotonic. The other three are improved sets of 6-bit linear codes: a compatibility set, an enhanced-mode set for standard conversions and an enhanced-mode set for injected conversions. The mode inputs and the injected flag choose the source. The chosen settings are captured when a start strobe is accepted, and they hold until that conversion's window has closed.

Top module: `adc_timing_gen`

## Requirements
- R1: With both mode inputs low, `leg_clk_i` sets the basic-clock period in module-clock cycles: code 0 gives 4, code 1 gives 2, code 2 gives 16 and code 3 gives 8.
- R2: With both mode inputs low, `leg_smp_i` code c sets the sampling window to 8·2^c basic-clock periods, that is 8, 16, 32 or 64.
- R3: In an improved mode, a 6-bit clock code k sets the basic-clock period to k+1 module-clock cycles (1 to 64).
- R4: In an improved mode, a 6-bit sample code s sets the window to 4·(s+2) basic-clock periods (8 to 260).
- R5: While an improved mode is active, the values on `leg_clk_i` and `leg_smp_i` have no effect on timing.
- R6: The source is chosen as follows. If `cmp_mode_i` is high, the compatibility set is used for every conversion, whatever the values of `enh_mode_i` and `inj_i`. Otherwise, if `enh_mode_i` is high, the standard set is used when `inj_i` is 0 and the injected set when `inj_i` is 1. Otherwise the legacy codes are used.
- R7: The settings and the injected flag are captured at the clock edge that accepts a start. Changes to them during the conversion do not alter its timing.
- R8: Over a conversion with period P, `bc_en_o` pulses for one cycle on the Pth edge after the accepting edge and then on every Pth edge. With P = 1 it is high on every cycle. It is low whenever no conversion is in progress.
- R9: `sampling_o` rises together with the first `bc_en_o` pulse of a conversion and stays high for exactly N·P module-clock cycles, where N is the window length in basic-clock periods.
- R10: `smp_done_o` is high for exactly one cycle: the cycle right after the last sampling cycle. That cycle also carries the final `bc_en_o` pulse of the conversion (N+1 pulses in all), and the conversion ends there.
- R11: A start strobe that arrives between an accepted start and the end of that conversion is ignored. It neither restarts nor extends the window, and it triggers no second conversion.
- R12: While `rst` is high, and on the first cycle after it falls, all three outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | ADC module clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Conversion start strobe |
| inj_i | input | 1 | Conversion is injected (used in enhanced mode) |
| cmp_mode_i | input | 1 | Compatibility mode: one improved set for all conversions |
| enh_mode_i | input | 1 | Enhanced mode: separate standard and injected sets |
| leg_clk_i | input | 2 | Legacy basic-clock code |
| leg_smp_i | input | 2 | Legacy sample-time code |
| cmp_clk_i | input | CLK_W | Compatibility set clock code |
| cmp_smp_i | input | SMP_W | Compatibility set sample code |
| std_clk_i | input | CLK_W | Enhanced standard set clock code |
| std_smp_i | input | SMP_W | Enhanced standard set sample code |
| inj_clk_i | input | CLK_W | Enhanced injected set clock code |
| inj_smp_i | input | SMP_W | Enhanced injected set sample code |
| bc_en_o | output | 1 | Basic-clock enable pulse |
| sampling_o | output | 1 | Sampling window active |
| smp_done_o | output | 1 | One-cycle pulse at the end of the window |

## Verification
The hardest situation to reach from the ports is a second start strobe, together with new field values, arriving partway through an open sampling window. Only the captured settings and the busy gate keep that window's timing intact. The bench opens a window and, a few cycles into it, raises the strobe again while it inverts every configuration input. It then checks that the first pulse, the window length, the done position and the pulse count all keep their original values. A trailing quiet stretch confirms that no second conversion starts. The extremes of the range (divide-by-1 with pulses on every cycle, and divide-by-64 with a 260-period window) are also run to the end.

// File: rtl/adc_tgen_pkg.sv
package adc_tgen_pkg;

  typedef enum logic [1:0] {
    SRC_LEGACY = 2'd0,
    SRC_COMPAT = 2'd1,
    SRC_STD    = 2'd2,
    SRC_INJ    = 2'd3
  } tgen_src_e;

  // Legacy clock code to (period - 1); the code order is not monotonic.
  function automatic logic [3:0] leg_div_m1(input logic [1:0] code);
    case (code)
      2'd0:    return 4'd3;
      2'd1:    return 4'd1;
      2'd2:    return 4'd15;
      default: return 4'd7;
    endcase
  endfunction

  // Legacy sample code to (periods - 1): 8 << code, minus one.
  function automatic logic [6:0] leg_smp_m1(input logic [1:0] code);
    return (7'd8 << code) - 7'd1;
  endfunction

endpackage

// File: rtl/adc_tgen_cfg.sv
module adc_tgen_cfg
  import adc_tgen_pkg::*;
#(
  parameter int CLK_W = 6,
  parameter int SMP_W = 6,
  localparam int CNT_W = SMP_W + 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic             inj_i,
  input  logic             cmp_mode_i,
  input  logic             enh_mode_i,
  input  logic [1:0]       leg_clk_i,
  input  logic [1:0]       leg_smp_i,
  input  logic [CLK_W-1:0] cmp_clk_i,
  input  logic [SMP_W-1:0] cmp_smp_i,
  input  logic [CLK_W-1:0] std_clk_i,
  input  logic [SMP_W-1:0] std_smp_i,
  input  logic [CLK_W-1:0] inj_clk_i,
  input  logic [SMP_W-1:0] inj_smp_i,
  output logic [CLK_W-1:0] div_m1_o,
  output logic [CNT_W-1:0] smp_m1_o
);

  tgen_src_e        src;
  logic [CLK_W-1:0] sel_clk;
  logic [SMP_W-1:0] sel_smp;
  logic [CLK_W-1:0] div_nx;
  logic [CNT_W-1:0] smp_nx;

  // Compatibility mode takes priority over enhanced mode.
  always_comb begin
    if (cmp_mode_i)      src = SRC_COMPAT;
    else if (enh_mode_i) src = inj_i ? SRC_INJ : SRC_STD;
    else                 src = SRC_LEGACY;
  end

  always_comb begin
    case (src)
      SRC_COMPAT: begin sel_clk = cmp_clk_i; sel_smp = cmp_smp_i; end
      SRC_STD:    begin sel_clk = std_clk_i; sel_smp = std_smp_i; end
      SRC_INJ:    begin sel_clk = inj_clk_i; sel_smp = inj_smp_i; end
      default:    begin sel_clk = '0;        sel_smp = '0;        end
    endcase
  end

  // Improved: period = code + 1; window = 4 * (code + 2) = 4 * code + 8.
  always_comb begin
    if (src == SRC_LEGACY) begin
      div_nx = CLK_W'(leg_div_m1(leg_clk_i));
      smp_nx = CNT_W'(leg_smp_m1(leg_smp_i));
    end else begin
      div_nx = sel_clk;
      smp_nx = (CNT_W'(sel_smp) << 2) + CNT_W'(7);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_m1_o <= '0;
      smp_m1_o <= '0;
    end else if (load_i) begin
      div_m1_o <= div_nx;
      smp_m1_o <= smp_nx;
    end
  end

  // R4: every captured window length is 8 or more periods
  smp_floor_chk: assert property (@(posedge clk) disable iff (rst)
    $past(load_i) |-> (smp_m1_o >= CNT_W'(7)));

endmodule

// File: rtl/adc_tgen_div.sv
module adc_tgen_div #(
  parameter int CLK_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic [CLK_W-1:0] div_m1_i,
  output logic             tick_o,
  output logic             bc_en_o
);

  logic [CLK_W-1:0] cnt;

  assign tick_o = run_i && (cnt == div_m1_i);

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      cnt     <= '0;
      bc_en_o <= 1'b0;
    end else if (tick_o) begin
      cnt     <= '0;
      bc_en_o <= 1'b1;
    end else begin
      cnt     <= cnt + 1'b1;
      bc_en_o <= 1'b0;
    end
  end

  // R8: no enable pulse unless a conversion was running
  bc_idle_chk: assert property (@(posedge clk) disable iff (rst)
    bc_en_o |-> $past(run_i));

  // R8: pulses stay isolated when the period is above one cycle
  bc_single_chk: assert property (@(posedge clk) disable iff (rst)
    (bc_en_o && run_i && div_m1_i != '0) |=> !bc_en_o);

endmodule

// File: rtl/adc_tgen_smp.sv
module adc_tgen_smp #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] smp_m1_i,
  output logic             end_o,
  output logic             sampling_o,
  output logic             done_o
);

  logic [CNT_W-1:0] scnt;

  assign end_o = tick_i && sampling_o && (scnt == smp_m1_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      scnt       <= '0;
      sampling_o <= 1'b0;
      done_o     <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!run_i) begin
        scnt       <= '0;
        sampling_o <= 1'b0;
      end else if (tick_i) begin
        if (!sampling_o) begin
          sampling_o <= 1'b1;
          scnt       <= '0;
        end else if (end_o) begin
          sampling_o <= 1'b0;
          done_o     <= 1'b1;
        end else begin
          scnt <= scnt + 1'b1;
        end
      end
    end
  end

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R10
  done_after_window_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> ($past(sampling_o) && !sampling_o));

  // R9
  window_opens_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sampling_o) |-> $past(tick_i));

endmodule

// File: rtl/adc_timing_gen.sv
module adc_timing_gen #(
  parameter int CLK_W = 6,
  parameter int SMP_W = 6,
  localparam int CNT_W = SMP_W + 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             inj_i,
  input  logic             cmp_mode_i,
  input  logic             enh_mode_i,
  input  logic [1:0]       leg_clk_i,
  input  logic [1:0]       leg_smp_i,
  input  logic [CLK_W-1:0] cmp_clk_i,
  input  logic [SMP_W-1:0] cmp_smp_i,
  input  logic [CLK_W-1:0] std_clk_i,
  input  logic [SMP_W-1:0] std_smp_i,
  input  logic [CLK_W-1:0] inj_clk_i,
  input  logic [SMP_W-1:0] inj_smp_i,
  output logic             bc_en_o,
  output logic             sampling_o,
  output logic             smp_done_o
);

  logic             busy;
  logic             start_acc;
  logic             tick;
  logic             win_end;
  logic [CLK_W-1:0] div_m1;
  logic [CNT_W-1:0] smp_m1;

  assign start_acc = start_i && !busy;

  always_ff @(posedge clk) begin
    if (rst)            busy <= 1'b0;
    else if (start_acc) busy <= 1'b1;
    else if (win_end)   busy <= 1'b0;
  end

  adc_tgen_cfg #(.CLK_W(CLK_W), .SMP_W(SMP_W)) u_cfg (
    .clk        (clk),
    .rst        (rst),
    .load_i     (start_acc),
    .inj_i      (inj_i),
    .cmp_mode_i (cmp_mode_i),
    .enh_mode_i (enh_mode_i),
    .leg_clk_i  (leg_clk_i),
    .leg_smp_i  (leg_smp_i),
    .cmp_clk_i  (cmp_clk_i),
    .cmp_smp_i  (cmp_smp_i),
    .std_clk_i  (std_clk_i),
    .std_smp_i  (std_smp_i),
    .inj_clk_i  (inj_clk_i),
    .inj_smp_i  (inj_smp_i),
    .div_m1_o   (div_m1),
    .smp_m1_o   (smp_m1)
  );

  adc_tgen_div #(.CLK_W(CLK_W)) u_div (
    .clk      (clk),
    .rst      (rst),
    .run_i    (busy),
    .div_m1_i (div_m1),
    .tick_o   (tick),
    .bc_en_o  (bc_en_o)
  );

  adc_tgen_smp #(.CNT_W(CNT_W)) u_smp (
    .clk        (clk),
    .rst        (rst),
    .run_i      (busy),
    .tick_i     (tick),
    .smp_m1_i   (smp_m1),
    .end_o      (win_end),
    .sampling_o (sampling_o),
    .done_o     (smp_done_o)
  );

  // R7
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(div_m1) && $stable(smp_m1)));

  // R11
  restart_block_chk: assert property (@(posedge clk) disable iff (rst)
    (sampling_o && start_i) |=> !$rose(busy));

  // R9
  window_in_conv_chk: assert property (@(posedge clk) disable iff (rst)
    sampling_o |-> busy);

  // R9
  window_first_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sampling_o) |-> bc_en_o);

endmodule

// File: tb/adc_timing_gen_bench.sv
module adc_timing_gen_bench;

  localparam int CLK_W = 6;
  localparam int SMP_W = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0, inj_i = 1'b0, cmp_mode_i = 1'b0, enh_mode_i = 1'b0;
  logic [1:0] leg_clk_i = '0, leg_smp_i = '0;
  logic [CLK_W-1:0] cmp_clk_i = '0, std_clk_i = '0, inj_clk_i = '0;
  logic [SMP_W-1:0] cmp_smp_i = '0, std_smp_i = '0, inj_smp_i = '0;
  logic bc_en_o, sampling_o, smp_done_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  adc_timing_gen #(.CLK_W(CLK_W), .SMP_W(SMP_W)) u_adc_timing_gen (
    .clk(clk), .rst(rst), .start_i(start_i), .inj_i(inj_i),
    .cmp_mode_i(cmp_mode_i), .enh_mode_i(enh_mode_i),
    .leg_clk_i(leg_clk_i), .leg_smp_i(leg_smp_i),
    .cmp_clk_i(cmp_clk_i), .cmp_smp_i(cmp_smp_i),
    .std_clk_i(std_clk_i), .std_smp_i(std_smp_i),
    .inj_clk_i(inj_clk_i), .inj_smp_i(inj_smp_i),
    .bc_en_o(bc_en_o), .sampling_o(sampling_o), .smp_done_o(smp_done_o)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles, expected under 190000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Runs one conversion and checks R8, R9, R10 (and R11 when poke_k > 0).
  task automatic run_conv(input int d, input int n, input string req, input int poke_k);
    int first_bc = -1, second_bc = -1, rise = -1, hi = 0, done_k = -1, done_cnt = 0, bcs = 0;
    int limit = d + n * d + 2 * d + 30;
    @(negedge clk) start_i = 1'b1;
    @(posedge clk);
    #2 start_i = 1'b0;
    for (int k = 1; k <= limit; k++) begin
      @(posedge clk);
      #2;
      if (bc_en_o) begin
        bcs++;
        if (first_bc < 0) first_bc = k;
        else if (second_bc < 0) second_bc = k;
      end
      if (sampling_o) begin
        hi++;
        if (rise < 0) rise = k;
      end
      if (smp_done_o) begin
        done_cnt++;
        if (done_k < 0) done_k = k;
      end
      if (poke_k > 0 && k == poke_k) begin
        start_i = 1'b1;
        leg_clk_i = ~leg_clk_i; leg_smp_i = ~leg_smp_i;
        cmp_clk_i = ~cmp_clk_i; cmp_smp_i = ~cmp_smp_i;
        std_clk_i = ~std_clk_i; std_smp_i = ~std_smp_i;
        inj_clk_i = ~inj_clk_i; inj_smp_i = ~inj_smp_i;
        inj_i = ~inj_i;
      end
      if (poke_k > 0 && k == poke_k + 1) start_i = 1'b0;
    end
    chk(req, "R8 first bc_en edge", first_bc, d);
    chk(req, "R8 second bc_en edge", second_bc, (n == 0) ? -1 : 2 * d);
    chk(req, "R8/R10 bc_en pulse count", bcs, n + 1);
    chk(req, "R9 window start", rise, d);
    chk(req, "R9 window length", hi, n * d);
    chk(req, "R10 done position", done_k, d + n * d);
    chk(req, "R10 done pulse count", done_cnt, 1);
  endtask

  task automatic set_modes(input bit c, input bit e, input bit inj);
    cmp_mode_i = c; enh_mode_i = e; inj_i = inj;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    chk("R12", "bc_en in reset", int'(bc_en_o), 0);
    chk("R12", "sampling in reset", int'(sampling_o), 0);
    chk("R12", "done in reset", int'(smp_done_o), 0);
    @(negedge clk) rst = 1'b0;
    @(posedge clk);
    #2;
    chk("R12", "bc_en after reset", int'(bc_en_o), 0);
    chk("R12", "sampling after reset", int'(sampling_o), 0);
    chk("R8", "idle bc_en", int'(bc_en_o), 0);
  endtask

  task automatic t_legacy_clk;
    int exp_p[4] = '{4, 2, 16, 8};
    set_modes(0, 0, 0);
    leg_smp_i = 2'd0;
    for (int c = 0; c < 4; c++) begin
      leg_clk_i = 2'(c);
      run_conv(exp_p[c], 8, "R1", 0);
    end
  endtask

  task automatic t_legacy_smp;
    set_modes(0, 0, 0);
    leg_clk_i = 2'd1;
    for (int c = 1; c < 4; c++) begin
      leg_smp_i = 2'(c);
      run_conv(2, 8 << c, "R2", 0);
    end
  endtask

  task automatic t_improved_range;
    set_modes(1, 0, 0);
    cmp_clk_i = 6'd0;  cmp_smp_i = 6'd0;
    run_conv(1, 8, "R3 R4 R8 divide-by-1", 0);
    cmp_clk_i = 6'd4;  cmp_smp_i = 6'd3;
    run_conv(5, 20, "R3 R4 mid", 0);
    cmp_clk_i = 6'd63; cmp_smp_i = 6'd63;
    run_conv(64, 260, "R3 R4 max", 0);
  endtask

  task automatic t_legacy_ignored;
    set_modes(1, 0, 0);
    cmp_clk_i = 6'd1; cmp_smp_i = 6'd2;
    leg_clk_i = 2'd2; leg_smp_i = 2'd3;
    run_conv(2, 16, "R5 legacy 2/3", 0);
    leg_clk_i = 2'd0; leg_smp_i = 2'd1;
    run_conv(2, 16, "R5 legacy 0/1", 0);
  endtask

  task automatic t_source_select;
    cmp_clk_i = 6'd1; cmp_smp_i = 6'd2;
    std_clk_i = 6'd2; std_smp_i = 6'd1;
    inj_clk_i = 6'd5; inj_smp_i = 6'd0;
    leg_clk_i = 2'd3; leg_smp_i = 2'd0;
    set_modes(0, 1, 0); run_conv(3, 12, "R6 enhanced standard", 0);
    set_modes(0, 1, 1); run_conv(6, 8, "R6 enhanced injected", 0);
    set_modes(1, 1, 1); run_conv(2, 16, "R6 compat over enhanced", 0);
    set_modes(1, 0, 1); run_conv(2, 16, "R6 compat injected", 0);
    set_modes(0, 0, 1); run_conv(8, 8, "R6 legacy", 0);
  endtask

  task automatic t_latch_restart;
    set_modes(0, 0, 0);
    leg_clk_i = 2'd1; leg_smp_i = 2'd0;
    run_conv(2, 8, "R7 R11 legacy poke", 5);
    set_modes(0, 1, 0);
    std_clk_i = 6'd2; std_smp_i = 6'd1;
    inj_clk_i = 6'd0; inj_smp_i = 6'd0;
    run_conv(3, 12, "R7 R11 enhanced poke", 1);
  endtask

  initial begin
    t_reset();
    t_legacy_clk();
    t_legacy_smp();
    t_improved_range();
    t_legacy_ignored();
    t_source_select();
    t_latch_restart();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule